// File: doc/BRIEF.md
# Display-identification data transfer engine

This block moves display-identification data between a byte-level serial bus slave and an on-chip byte memory. The bus slave sits outside the block. It decodes the bit protocol and hands over byte events: a start or repeated start, an address match for a write, an address match for a read, and a stop. Written bytes arrive on a valid/ready stream. Read bytes are requested on a valid/ready request channel and come back on a valid/ready response channel. The memory macro is also outside the block. The block drives its address, write strobe, write data and read enable, and it takes back read data one cycle after a read enable.

In a write transfer, the first byte after the address match is a sub-address. It loads the internal relative address counter. Every later byte goes to memory at the counter's position, and the counter then advances by one. In a read transfer, each request returns the byte at the counter's position and advances the counter. The counter wraps at the end of the data structure and keeps its value across transfers, so a read with no sub-address continues where the last transfer stopped.

A software base register supplies the upper bits of the physical memory address, and the counter supplies the lower bits. A write-protect control suppresses memory writes but leaves the bus transfer running. A completion flag is set when the final structure byte is written, and it can raise an interrupt.

Back-pressure rules:
- A written byte is taken only on a cycle where `wr_valid` and `wr_ready` are both high.
- A read request is taken only on a cycle where `rd_req_valid` and `rd_req_ready` are both high.
- `rd_req_ready` stays low while a previous response is pending or unconsumed.
- Once `rd_valid` rises, it stays high with `rd_data` stable until `rd_ready` is high.

Top module: `edid_xfer_engine`

## Requirements
- R1: After reset, the following are low: `flag`, `irq`, `mem_we`, `mem_re`, `rd_valid`, `wr_ready` and `rd_req_ready`. The relative counter is 0, so the first read after reset returns relative location 0.
- R2: After `ev_addr_wr`, the first accepted byte loads its low REL_AW bits into the counter, and it is not written to memory (`mem_we` stays low).
- R3: Each later accepted byte of a write transfer is written with `mem_we` high at the counter position, and the counter then advances by one. It wraps from 2^REL_AW-1 to 0; with the default of 7 bits, it wraps from 7Fh to 00h.
- R4: `mem_addr` is `{base_hi, counter}`: `base_hi` occupies the upper PHYS_AW-REL_AW bits and the counter the lower REL_AW bits.
- R5: While `wp` is 1, data bytes are still accepted (`wr_ready` high) and the counter still advances, but `mem_we` stays low and memory content is unchanged.
- R6: `flag` is set on the cycle after a memory write to relative address all-ones (7Fh by default). A write suppressed by `wp` does not set it. It stays set until `flag_clr` is 1, which clears it; a set on the same cycle as a clear wins.
- R7: `irq` is high exactly when `flag` is high and `irq_en` is 1.
- R8: Each accepted read request issues `mem_re` at the current physical address and advances the counter. Two cycles later, `rd_valid` rises with that byte on `rd_data`. Both hold until `rd_ready`.
- R9: `wr_ready` is high only inside a write transfer. `rd_req_ready` is high only inside a read transfer, with no response pending. `ev_start` and `ev_stop` end any transfer.
- R10: The counter keeps its value across a stop and start. A read transfer with no sub-address begins at the location after the last byte transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen on the bus |
| ev_stop | input | 1 | Stop seen on the bus |
| ev_addr_wr | input | 1 | Device address matched, write direction |
| ev_addr_rd | input | 1 | Device address matched, read direction |
| wr_valid | input | 1 | Received byte available |
| wr_data | input | DW | Received byte |
| wr_ready | output | 1 | Received byte accepted |
| rd_req_valid | input | 1 | Bus wants the next byte to transmit |
| rd_req_ready | output | 1 | Read request accepted |
| rd_valid | output | 1 | Byte to transmit is available |
| rd_data | output | DW | Byte to transmit |
| rd_ready | input | 1 | Bus has taken the byte |
| wp | input | 1 | Write protect: suppress memory writes |
| base_hi | input | PHYS_AW-REL_AW | Upper physical address bits |
| irq_en | input | 1 | Interrupt enable for the completion flag |
| flag_clr | input | 1 | Write 1 to clear the completion flag |
| flag | output | 1 | Final structure byte written |
| irq | output | 1 | Interrupt request |
| mem_addr | output | PHYS_AW | Memory physical address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_re | output | 1 | Memory read enable; data is expected on mem_rdata one cycle later |
| mem_rdata | input | DW | Memory read data |

## Verification
The bench builds the block with REL_AW=4 and PHYS_AW=6, which gives a 16-byte structure and four base windows. With that configuration, every relative location in every window can be written and read back. The wrap from 0Fh to 00h and the completion flag come up within a few bytes of each other. The sub-address for each window is different, so every write sweep crosses the wrap at a different point of the transfer.

// File: rtl/edid_pkg.sv
package edid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WSUB = 2'd1,
    ST_WDAT = 2'd2,
    ST_RD   = 2'd3
  } xfer_st_t;
endpackage

// File: rtl/edid_seq.sv
module edid_seq
  import edid_pkg::*;
#(
  parameter int DW     = 8,
  parameter int REL_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_addr_wr,
  input  logic              ev_addr_rd,
  input  logic              wr_valid,
  input  logic [DW-1:0]     wr_data,
  output logic              wr_ready,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic              rd_busy,
  input  logic              wp,
  output logic [REL_AW-1:0] ctr,
  output logic              we,
  output logic              re
);
  xfer_st_t st;
  logic any_ev, wr_acc, rd_acc;

  assign any_ev       = ev_start | ev_stop | ev_addr_wr | ev_addr_rd;
  assign wr_ready     = ((st == ST_WSUB) || (st == ST_WDAT)) && !any_ev;
  assign rd_req_ready = (st == ST_RD) && !any_ev && !rd_busy;
  assign wr_acc       = wr_valid && wr_ready;
  assign rd_acc       = rd_req_valid && rd_req_ready;
  assign we           = wr_acc && (st == ST_WDAT) && !wp;
  assign re           = rd_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      ctr <= '0;
    end else if (ev_start || ev_stop) begin
      st <= ST_IDLE;
    end else if (ev_addr_wr) begin
      st <= ST_WSUB;
    end else if (ev_addr_rd) begin
      st <= ST_RD;
    end else if (wr_acc) begin
      if (st == ST_WSUB) begin
        ctr <= wr_data[REL_AW-1:0];
        st  <= ST_WDAT;
      end else begin
        ctr <= ctr + 1'b1;
      end
    end else if (rd_acc) begin
      ctr <= ctr + 1'b1;
    end
  end
endmodule

// File: rtl/edid_map.sv
module edid_map #(
  parameter int REL_AW  = 7,
  parameter int PHYS_AW = 10
) (
  input  logic [PHYS_AW-REL_AW-1:0] base_hi,
  input  logic [REL_AW-1:0]         rel,
  output logic [PHYS_AW-1:0]        phys
);
  assign phys = {base_hi, rel};
endmodule

// File: rtl/edid_rd_buf.sv
module edid_rd_buf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [DW-1:0] mem_rdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_ready,
  output logic          busy
);
  logic pend;

  assign busy = pend | rd_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pend <= re;
      if (pend) begin
        rd_valid <= 1'b1;
        rd_data  <= mem_rdata;
      end else if (rd_valid && rd_ready) begin
        rd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/edid_done.sv
module edid_done #(
  parameter int REL_AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REL_AW-1:0] rel,
  input  logic              flag_clr,
  input  logic              irq_en,
  output logic              flag,
  output logic              irq
);
  localparam logic [REL_AW-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                    flag <= 1'b0;
    else if (we && (rel == LAST))  flag <= 1'b1;
    else if (flag_clr)             flag <= 1'b0;
  end

  assign irq = flag & irq_en;
endmodule

// File: rtl/edid_xfer_engine.sv
module edid_xfer_engine #(
  parameter int DW      = 8,
  parameter int REL_AW  = 7,
  parameter int PHYS_AW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_start,
  input  logic                      ev_stop,
  input  logic                      ev_addr_wr,
  input  logic                      ev_addr_rd,
  input  logic                      wr_valid,
  input  logic [DW-1:0]             wr_data,
  output logic                      wr_ready,
  input  logic                      rd_req_valid,
  output logic                      rd_req_ready,
  output logic                      rd_valid,
  output logic [DW-1:0]             rd_data,
  input  logic                      rd_ready,
  input  logic                      wp,
  input  logic [PHYS_AW-REL_AW-1:0] base_hi,
  input  logic                      irq_en,
  input  logic                      flag_clr,
  output logic                      flag,
  output logic                      irq,
  output logic [PHYS_AW-1:0]        mem_addr,
  output logic                      mem_we,
  output logic [DW-1:0]             mem_wdata,
  output logic                      mem_re,
  input  logic [DW-1:0]             mem_rdata
);
  logic [REL_AW-1:0] ctr;
  logic              busy;

  edid_seq #(.DW(DW), .REL_AW(REL_AW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_addr_wr(ev_addr_wr), .ev_addr_rd(ev_addr_rd),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_busy(busy), .wp(wp), .ctr(ctr), .we(mem_we), .re(mem_re)
  );

  edid_map #(.REL_AW(REL_AW), .PHYS_AW(PHYS_AW)) u_map (
    .base_hi(base_hi), .rel(ctr), .phys(mem_addr)
  );

  edid_rd_buf #(.DW(DW)) u_rbuf (
    .clk(clk), .rst_n(rst_n), .re(mem_re), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .busy(busy)
  );

  edid_done #(.REL_AW(REL_AW)) u_done (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .rel(ctr),
    .flag_clr(flag_clr), .irq_en(irq_en), .flag(flag), .irq(irq)
  );

  assign mem_wdata = wr_data;
endmodule

// File: rtl/edid_xfer_chk.sv
module edid_xfer_chk #(
  parameter int DW      = 8,
  parameter int REL_AW  = 7,
  parameter int PHYS_AW = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wp,
  input logic               mem_we,
  input logic [PHYS_AW-1:0] mem_addr,
  input logic               flag,
  input logic               flag_clr,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [DW-1:0]      rd_data,
  input logic               wr_valid,
  input logic               wr_ready
);
  localparam logic [REL_AW-1:0] LAST = '1;

  p_wp_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wp |-> !mem_we);

  p_we_needs_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_valid && wr_ready));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |->
      (mem_addr[REL_AW-1:0] == $past(mem_addr[REL_AW-1:0]) + 1'b1));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (mem_addr[REL_AW-1:0] == LAST)) |=> flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind edid_xfer_engine edid_xfer_chk #(.DW(DW), .REL_AW(REL_AW), .PHYS_AW(PHYS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr),
  .flag(flag), .flag_clr(flag_clr), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .wr_valid(wr_valid), .wr_ready(wr_ready)
);

// File: tb/edid_xfer_engine_bench.sv
module edid_xfer_engine_bench;
  localparam int DW = 8, RA = 4, PA = 6, BW = PA - RA, NB = 1 << BW, NR = 1 << RA;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_addr_wr = 0, ev_addr_rd = 0;
  logic wr_valid = 0, rd_req_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_req_ready, rd_valid, flag, irq, mem_we, mem_re;
  logic [DW-1:0] rd_data, mem_wdata, mem_rdata;
  logic [PA-1:0] mem_addr;
  logic wp = 0, irq_en = 0, flag_clr = 0;
  logic [BW-1:0] base_hi = '0;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [0:(1<<PA)-1];
  logic [DW-1:0] exp_mem [0:(1<<PA)-1];

  always #5 clk = ~clk;

  edid_xfer_engine #(.DW(DW), .REL_AW(RA), .PHYS_AW(PA)) u_edid_xfer_engine (.*);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [DW-1:0] pat(int b, int r);
    return DW'((b * NR + r) * 37 + 11);
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int k);
    @(posedge clk); #1;
    case (k)
      0: ev_start = 1;
      1: ev_stop = 1;
      2: ev_addr_wr = 1;
      default: ev_addr_rd = 1;
    endcase
    @(posedge clk); #1;
    ev_start = 0; ev_stop = 0; ev_addr_wr = 0; ev_addr_rd = 0;
  endtask

  // Send one byte; exp_we/exp_a describe the expected memory strobe
  task automatic wbyte(input logic [DW-1:0] d, input logic exp_we, input int exp_a, input string tag);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    chk(wr_ready == 1'b1, {tag, " wr_ready"}, wr_ready, 1);
    chk(mem_we == exp_we, {tag, " mem_we"}, mem_we, exp_we);
    if (exp_we) chk(mem_addr == PA'(exp_a), {tag, " mem_addr"}, mem_addr, exp_a);
    @(posedge clk); #1;
    wr_valid = 0;
  endtask

  task automatic rbyte(input int exp_a, input string tag);
    rd_req_valid = 1;
    @(negedge clk);
    chk(rd_req_ready == 1'b1, {tag, " req_ready"}, rd_req_ready, 1);
    chk(mem_re && mem_addr == PA'(exp_a), {tag, " rd addr"}, mem_addr, exp_a);
    @(posedge clk); #1;
    rd_req_valid = 0;
    @(posedge clk); #1;
    @(negedge clk);
    chk(rd_valid && rd_data == exp_mem[exp_a], {tag, " rd_data"}, rd_data, exp_mem[exp_a]);
    @(posedge clk); #1;
    @(negedge clk);
    chk(rd_valid && rd_data == exp_mem[exp_a], {tag, " rd hold"}, rd_data, exp_mem[exp_a]);
    rd_ready = 1;
    @(posedge clk); #1;
    rd_ready = 0;
  endtask

  initial begin
    for (int i = 0; i < (1 << PA); i++) begin
      mem[i] = DW'(i ^ 8'h5A);
      exp_mem[i] = DW'(i ^ 8'h5A);
    end
    #200000000;
    errors++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!flag && !irq && !mem_we && !mem_re && !rd_valid, "R1 outputs low", {flag, irq, mem_we, mem_re, rd_valid}, 0);
    chk(!wr_ready && !rd_req_ready, "R1 R9 ready low idle", {wr_ready, rd_req_ready}, 0);
    // R1 counter starts at 0: first read hits relative 0
    pulse(0); pulse(3);
    rbyte(0, "R1 R8 first read");
    // R9: write byte not accepted in read transfer
    wr_valid = 1;
    @(negedge clk);
    chk(!wr_ready && !mem_we, "R9 wr_ready low in read", wr_ready, 0);
    @(posedge clk); #1 wr_valid = 0;
    pulse(1);
    @(negedge clk);
    chk(!rd_req_ready && !wr_ready, "R9 ready low after stop", rd_req_ready, 0);

    // R2 R3 R4 full sweep of every window with distinct sub-addresses
    for (int b = 0; b < NB; b++) begin
      int s;
      s = (b * 5 + 3) % NR;
      base_hi = BW'(b);
      pulse(0); pulse(2);
      wbyte(DW'(s), 1'b0, 0, "R2 subaddr no write");
      for (int i = 0; i < NR; i++) begin
        int r;
        r = (s + i) % NR;
        wbyte(pat(b, r), 1'b1, b * NR + r, "R3 R4 write");
        exp_mem[b * NR + r] = pat(b, r);
      end
      pulse(1);
    end
    // R8 R4 read back every location
    for (int b = 0; b < NB; b++) begin
      base_hi = BW'(b);
      pulse(0); pulse(2);
      wbyte(8'h00, 1'b0, 0, "R2 subaddr");
      pulse(0); pulse(3);
      for (int r = 0; r < NR; r++) rbyte(b * NR + r, "R8 R4 readback");
      pulse(1);
    end

    // R10 counter persists across transfers
    base_hi = 2'd2;
    pulse(0); pulse(2);
    wbyte(8'h05, 1'b0, 0, "R2 subaddr");
    wbyte(8'hC1, 1'b1, 2 * NR + 5, "R3 write");
    exp_mem[2 * NR + 5] = 8'hC1;
    wbyte(8'hC2, 1'b1, 2 * NR + 6, "R3 write");
    exp_mem[2 * NR + 6] = 8'hC2;
    pulse(1); pulse(0); pulse(3);
    rbyte(2 * NR + 7, "R10 current-address read");
    pulse(1);

    // R5 write protect
    wp = 1; base_hi = 2'd1;
    pulse(0); pulse(2);
    wbyte(8'h03, 1'b0, 0, "R5 subaddr");
    for (int i = 0; i < 3; i++) wbyte(8'hEE, 1'b0, 0, "R5 protected");
    pulse(1); wp = 0;
    pulse(0); pulse(3);
    rbyte(NR + 6, "R5 counter advanced");
    pulse(1);
    pulse(0); pulse(2);
    wbyte(8'h03, 1'b0, 0, "R2 subaddr");
    pulse(0); pulse(3);
    rbyte(NR + 3, "R5 content unchanged");
    rbyte(NR + 4, "R5 content unchanged");
    pulse(1);

    // R6 R7 flag and interrupt (flag was set by the sweep)
    @(negedge clk);
    chk(flag == 1'b1, "R6 flag after last byte", flag, 1);
    chk(irq == 1'b0, "R7 irq masked", irq, 0);
    irq_en = 1;
    @(negedge clk);
    chk(irq == 1'b1, "R7 irq enabled", irq, 1);
    @(posedge clk); #1 flag_clr = 1;
    @(posedge clk); #1 flag_clr = 0;
    @(negedge clk);
    chk(!flag && !irq, "R6 R7 cleared", {flag, irq}, 0);
    // protected write of last byte does not set flag
    wp = 1;
    pulse(0); pulse(2);
    wbyte(DW'(NR - 1), 1'b0, 0, "R6 subaddr");
    wbyte(8'h77, 1'b0, 0, "R6 protected last");
    pulse(1); wp = 0;
    @(negedge clk);
    chk(!flag, "R6 no flag under wp", flag, 0);
    // unprotected write of last byte sets it, even with clear held (set wins)
    pulse(0); pulse(2);
    wbyte(DW'(NR - 2), 1'b0, 0, "R6 subaddr");
    wbyte(8'h55, 1'b1, NR + NR - 2, "R6 write");
    flag_clr = 1;
    wbyte(8'h66, 1'b1, NR + NR - 1, "R6 write last");
    @(negedge clk);
    chk(flag && irq, "R6 set wins over clear", flag, 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(!flag, "R6 clear after set", flag, 0);
    flag_clr = 0;
    pulse(1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule